// File: doc/BRIEF.md
# K-Winner Threshold Selector

This block picks roughly the K highest-scoring entries out of a large population without sorting them. A start strobe begins a walk over a score histogram. The walk starts at the top bin and moves toward bin 0, adding each bin's count to a running total. It stops as soon as the total reaches K. The index one below the last bin added becomes the threshold, so every entry in the bins that were added lies strictly above it.

A second pass then reads every entry's stored score, one entry per cycle. Each score is compared strictly against the threshold, and the resulting bits are packed into 32-bit words that are written out in ascending order. The block also gives a secondary threshold, one quarter of the final running total, for the matching stage that follows. A one-cycle done pulse marks the end of the run.

The histogram and score memories sit outside the block. Both are read through synchronous ports with one cycle of latency.

Top module: `kwta_select`

## Requirements
- R1: During reset and directly after it, `done`, `vec_wr_en`, `hist_rd_en` and `score_rd_en` are 0, and `thresh` and `thresh2` are 0.
- R2: An accepted start reads histogram bins beginning at index MAX_BIN, one bin lower on each read, and adds each count to a running total. No further bin is read once the total is at least K_WIN. `thresh` is set to the index one below the last bin read, and the number of bins read is MAX_BIN minus `thresh`.
- R3: If the total never reaches K_WIN, the walk ends after bin 1, `thresh` is 0, and bin 0 is never read.
- R4: For each entry e, bit e%32 of word e/32 is 1 exactly when the entry's score is strictly greater than `thresh`, and 0 when it is equal or lower. `thresh` does not change while scores are being read.
- R5: At `done`, `thresh2` equals the final running total divided by 4, rounded down.
- R6: Each run writes N_ENTRIES/32 words, each word once, at addresses 0, 1, 2 and so on in ascending order.
- R7: `done` is high for exactly one cycle, which is the cycle of the final word write (the highest address). `thresh` and `thresh2` then keep their values until the next accepted start.
- R8: A start that arrives while a run is in progress, including the cycle in which `done` is high, is ignored. It neither restarts the walk nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection run when idle |
| hist_rd_en | output | 1 | Histogram read request |
| hist_rd_addr | output | BIN_W (7) | Histogram bin index |
| hist_rd_data | input | CNT_W (13) | Bin count, one cycle after the request |
| score_rd_en | output | 1 | Score memory read request |
| score_rd_addr | output | log2(N_ENTRIES) | Entry index |
| score_rd_data | input | SCORE_W (7) | Entry score, one cycle after the request |
| vec_wr_en | output | 1 | Output word write strobe |
| vec_wr_addr | output | log2(N_ENTRIES/32) | Output word index |
| vec_wr_data | output | 32 | Winner bits for 32 consecutive entries |
| thresh | output | BIN_W (7) | Selected threshold |
| thresh2 | output | TOTAL_W (14) | Secondary threshold, a quarter of the final running total |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The end-of-run pulse and the write of the last packed word fall in the same cycle. A start request can also land in that cycle, while the block still counts as busy. The bench raises start exactly in the cycle where it sees `done`. It then confirms that the final word was written at the top address in that same cycle, and that no histogram read or second `done` follows. A further start in the middle of the histogram walk is judged by the number of bin reads, which must still equal MAX_BIN minus the threshold.

// File: rtl/kwta_pkg.sv
package kwta_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_REQ,
        HS_ACC
    } hs_state_e;

    typedef struct packed {
        logic valid;
        logic hit;
    } cmp_slot_t;

    function automatic logic [31:0] quarter_of(input logic [31:0] v);
        return v >> 2;
    endfunction

endpackage

// File: rtl/kwta_hist_scan.sv
module kwta_hist_scan
    import kwta_pkg::*;
#(
    parameter int MAX_BIN = 120,
    parameter int K_WIN   = 512,
    parameter int CNT_W   = 13,
    parameter int BIN_W   = 7,
    parameter int TOTAL_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    output logic               hist_rd_en,
    output logic [BIN_W-1:0]   hist_rd_addr,
    input  logic [CNT_W-1:0]   hist_rd_data,
    output logic [BIN_W-1:0]   thr,
    output logic [TOTAL_W-1:0] total,
    output logic               fin
);
    localparam logic [TOTAL_W-1:0] K_TOT = TOTAL_W'(K_WIN);

    hs_state_e          state;
    logic [BIN_W-1:0]   bin;
    logic [TOTAL_W-1:0] sum;

    assign hist_rd_en   = (state == HS_REQ);
    assign hist_rd_addr = bin;
    assign sum          = total + TOTAL_W'(hist_rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            bin   <= '0;
            thr   <= '0;
            total <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (state)
                HS_IDLE: begin
                    if (go) begin
                        bin   <= BIN_W'(MAX_BIN);
                        total <= '0;
                        state <= HS_REQ;
                    end
                end
                HS_REQ: state <= HS_ACC;
                HS_ACC: begin
                    total <= sum;
                    if (sum >= K_TOT || bin == BIN_W'(1)) begin
                        thr   <= bin - BIN_W'(1);
                        fin   <= 1'b1;
                        state <= HS_IDLE;
                    end else begin
                        bin   <= bin - BIN_W'(1);
                        state <= HS_REQ;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/kwta_vec_gen.sv
module kwta_vec_gen
    import kwta_pkg::*;
#(
    parameter int N_ENTRIES = 8192,
    parameter int SCORE_W   = 7,
    parameter int BIN_W     = 7,
    parameter int WORD_W    = 32,
    parameter int ENTRY_AW  = 13,
    parameter int WORD_AW   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [BIN_W-1:0]    thr,
    output logic                score_rd_en,
    output logic [ENTRY_AW-1:0] score_rd_addr,
    input  logic [SCORE_W-1:0]  score_rd_data,
    output logic                vec_wr_en,
    output logic [WORD_AW-1:0]  vec_wr_addr,
    output logic [WORD_W-1:0]   vec_wr_data,
    output logic                last
);
    localparam int LOW_W = $clog2(WORD_W);
    localparam int CMP_W = (SCORE_W > BIN_W) ? SCORE_W : BIN_W;

    logic                run;
    logic [ENTRY_AW-1:0] cnt;
    logic [ENTRY_AW-1:0] pidx;
    logic [WORD_W-1:0]   word_q;
    cmp_slot_t           slot;

    assign score_rd_en   = run;
    assign score_rd_addr = cnt;
    assign slot.hit      = CMP_W'(score_rd_data) > CMP_W'(thr);

    assign vec_wr_en   = slot.valid && (pidx[LOW_W-1:0] == '1);
    assign vec_wr_addr = pidx[ENTRY_AW-1:LOW_W];
    assign last        = vec_wr_en && (pidx == ENTRY_AW'(N_ENTRIES - 1));

    always_comb begin
        vec_wr_data = word_q;
        vec_wr_data[pidx[LOW_W-1:0]] = slot.hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run        <= 1'b0;
            cnt        <= '0;
            pidx       <= '0;
            word_q     <= '0;
            slot.valid <= 1'b0;
        end else begin
            slot.valid <= run;
            pidx       <= cnt;
            if (slot.valid)
                word_q[pidx[LOW_W-1:0]] <= slot.hit;
            if (run) begin
                cnt <= cnt + ENTRY_AW'(1);
                if (cnt == ENTRY_AW'(N_ENTRIES - 1))
                    run <= 1'b0;
            end else if (go) begin
                run <= 1'b1;
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/kwta_select.sv
module kwta_select
    import kwta_pkg::*;
#(
    parameter int N_ENTRIES = 8192,
    parameter int MAX_BIN   = 120,
    parameter int K_WIN     = 512,
    parameter int CNT_W     = 13,
    parameter int SCORE_W   = 7,
    parameter int WORD_W    = 32,
    localparam int BIN_W    = $clog2(MAX_BIN + 1),
    localparam int KW_W     = $clog2(K_WIN + 1),
    localparam int TOTAL_W  = ((CNT_W > KW_W) ? CNT_W : KW_W) + 1,
    localparam int ENTRY_AW = $clog2(N_ENTRIES),
    localparam int WORD_AW  = ENTRY_AW - $clog2(WORD_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                hist_rd_en,
    output logic [BIN_W-1:0]    hist_rd_addr,
    input  logic [CNT_W-1:0]    hist_rd_data,
    output logic                score_rd_en,
    output logic [ENTRY_AW-1:0] score_rd_addr,
    input  logic [SCORE_W-1:0]  score_rd_data,
    output logic                vec_wr_en,
    output logic [WORD_AW-1:0]  vec_wr_addr,
    output logic [WORD_W-1:0]   vec_wr_data,
    output logic [BIN_W-1:0]    thresh,
    output logic [TOTAL_W-1:0]  thresh2,
    output logic                done
);
    logic               busy;
    logic               accept;
    logic               scan_fin;
    logic [TOTAL_W-1:0] run_total;

    assign accept  = start && !busy;
    assign thresh2 = TOTAL_W'(quarter_of(32'(run_total)));

    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else if (accept)
            busy <= 1'b1;
        else if (done)
            busy <= 1'b0;
    end

    kwta_hist_scan #(
        .MAX_BIN(MAX_BIN), .K_WIN(K_WIN), .CNT_W(CNT_W),
        .BIN_W(BIN_W), .TOTAL_W(TOTAL_W)
    ) u_scan (
        .clk(clk), .rst(rst), .go(accept),
        .hist_rd_en(hist_rd_en), .hist_rd_addr(hist_rd_addr),
        .hist_rd_data(hist_rd_data),
        .thr(thresh), .total(run_total), .fin(scan_fin)
    );

    kwta_vec_gen #(
        .N_ENTRIES(N_ENTRIES), .SCORE_W(SCORE_W), .BIN_W(BIN_W),
        .WORD_W(WORD_W), .ENTRY_AW(ENTRY_AW), .WORD_AW(WORD_AW)
    ) u_vec (
        .clk(clk), .rst(rst), .go(scan_fin), .thr(thresh),
        .score_rd_en(score_rd_en), .score_rd_addr(score_rd_addr),
        .score_rd_data(score_rd_data),
        .vec_wr_en(vec_wr_en), .vec_wr_addr(vec_wr_addr),
        .vec_wr_data(vec_wr_data), .last(done)
    );
endmodule

// File: rtl/kwta_select_chk.sv
module kwta_select_chk #(
    parameter int MAX_BIN = 120,
    parameter int BIN_W   = 7,
    parameter int WORD_AW = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               hist_rd_en,
    input logic [BIN_W-1:0]   hist_rd_addr,
    input logic               score_rd_en,
    input logic               vec_wr_en,
    input logic [WORD_AW-1:0] vec_wr_addr,
    input logic [BIN_W-1:0]   thresh,
    input logic               done
);
    logic               have_prev;
    logic [BIN_W-1:0]   prev_addr;
    logic [WORD_AW-1:0] next_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
            next_wr   <= '0;
        end else begin
            if (start && !busy) begin
                have_prev <= 1'b0;
                next_wr   <= '0;
            end else begin
                if (hist_rd_en) begin
                    have_prev <= 1'b1;
                    prev_addr <= hist_rd_addr;
                end
                if (vec_wr_en)
                    next_wr <= next_wr + WORD_AW'(1);
            end
        end
    end

    AST_HIST_FIRST: assert property (@(posedge clk) disable iff (rst)
        hist_rd_en && !have_prev |-> hist_rd_addr == BIN_W'(MAX_BIN)); // R2
    AST_HIST_DESCEND: assert property (@(posedge clk) disable iff (rst)
        hist_rd_en && have_prev |-> hist_rd_addr == prev_addr - BIN_W'(1)); // R2
    AST_NO_BIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        hist_rd_en |-> hist_rd_addr != '0); // R3
    AST_THR_FIXED: assert property (@(posedge clk) disable iff (rst)
        score_rd_en |-> $stable(thresh)); // R4
    AST_WR_ORDER: assert property (@(posedge clk) disable iff (rst)
        vec_wr_en |-> vec_wr_addr == next_wr); // R6
    AST_DONE_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> vec_wr_en && vec_wr_addr == '1); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        done && start |=> !busy && !hist_rd_en); // R8
endmodule

bind kwta_select kwta_select_chk #(
    .MAX_BIN(MAX_BIN), .BIN_W(BIN_W), .WORD_AW(WORD_AW)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .hist_rd_en(hist_rd_en), .hist_rd_addr(hist_rd_addr),
    .score_rd_en(score_rd_en), .vec_wr_en(vec_wr_en),
    .vec_wr_addr(vec_wr_addr), .thresh(thresh), .done(done)
);

// File: tb/tb_kwta_select.sv
`timescale 1ns/1ps
module tb_kwta_select;
    localparam int N     = 128;
    localparam int MAXB  = 120;
    localparam int K     = 20;
    localparam int WORDS = N / 32;

    typedef struct packed {
        logic [1:0] mode;
        int         a;
        int         b;
    } vec_t;

    // mode 0: (e*a+b)%121   mode 1: e<a ? b : 10   mode 2: e%a
    localparam vec_t VECS [6] = '{
        '{2'd0, 7, 3},
        '{2'd0, 0, 120},
        '{2'd0, 0, 0},
        '{2'd2, 5, 0},
        '{2'd1, 20, 100},
        '{2'd1, 19, 100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        hist_rd_en;
    logic [6:0]  hist_rd_addr;
    logic [12:0] hist_rd_data;
    logic        score_rd_en;
    logic [6:0]  score_rd_addr;
    logic [6:0]  score_rd_data;
    logic        vec_wr_en;
    logic [1:0]  vec_wr_addr;
    logic [31:0] vec_wr_data;
    logic [6:0]  thresh;
    logic [13:0] thresh2;
    logic        done;

    int          checks = 0;
    int          fails = 0;
    int          scores [N];
    logic [12:0] hist [MAXB+1];
    logic [31:0] got [WORDS];
    int          rd_cnt, wr_cnt, done_cnt, done_on_last, bin0_reads;

    always #4 clk = ~clk;

    kwta_select #(
        .N_ENTRIES(N), .MAX_BIN(MAXB), .K_WIN(K),
        .CNT_W(13), .SCORE_W(7), .WORD_W(32)
    ) dut (.*);

    always @(posedge clk) begin
        if (hist_rd_en)  hist_rd_data  <= hist[hist_rd_addr];
        if (score_rd_en) score_rd_data <= 7'(scores[score_rd_addr]);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (hist_rd_en) rd_cnt++;
            if (hist_rd_en && hist_rd_addr == 0) bin0_reads++;
            if (vec_wr_en) begin
                got[vec_wr_addr] = vec_wr_data;
                wr_cnt++;
            end
            if (done) begin
                done_cnt++;
                if (vec_wr_en && vec_wr_addr == 2'(WORDS - 1)) done_on_last++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic run_case(input int mode, input int a, input int b,
                            input bit extra_start, input bit start_at_done);
        int total, i, exp_thr, exp_t2, to;
        int cap_thr, cap_t2;
        logic [31:0] ew;
        for (int e = 0; e < N; e++)
            scores[e] = (mode == 0) ? (e * a + b) % 121 :
                        (mode == 1) ? ((e < a) ? b : 10) : e % a;
        for (int h = 0; h <= MAXB; h++) hist[h] = '0;
        for (int e = 0; e < N; e++) hist[scores[e]] = hist[scores[e]] + 13'd1;
        total = 0; i = MAXB;
        while (total < K && i != 0) begin
            total += int'(hist[i]);
            i--;
        end
        exp_thr = i; exp_t2 = total / 4;
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; done_on_last = 0; bin0_reads = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (extra_start) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        to = 0;
        while (!done && to < 5000) begin
            @(negedge clk);
            to++;
        end
        chk(done, "R7", "done seen before timeout", done, 1);
        cap_thr = thresh; cap_t2 = thresh2;
        if (start_at_done) begin
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk(cap_thr == exp_thr, (i == 0) ? "R3" : "R2", "threshold", cap_thr, exp_thr);
        chk(rd_cnt == MAXB - exp_thr, "R2", "bin reads", rd_cnt, MAXB - exp_thr);
        chk(bin0_reads == 0, "R3", "reads of bin 0", bin0_reads, 0);
        chk(cap_t2 == exp_t2, "R5", "secondary threshold", cap_t2, exp_t2);
        chk(wr_cnt == WORDS, "R6", "word writes", wr_cnt, WORDS);
        chk(done_cnt == 1 && done_on_last == 1, "R7", "done pulses on last write",
            done_cnt * 10 + done_on_last, 11);
        chk(thresh == cap_thr && thresh2 == cap_t2, "R7", "threshold held after done",
            thresh, cap_thr);
        for (int w = 0; w < WORDS; w++) begin
            for (int bt = 0; bt < 32; bt++) ew[bt] = (scores[w*32+bt] > exp_thr);
            chk(got[w] == ew, "R4", $sformatf("vector word %0d", w), got[w], ew);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        for (int h = 0; h <= MAXB; h++) hist[h] = '0;
        for (int e = 0; e < N; e++) scores[e] = 0;
        repeat (3) @(negedge clk);
        chk(!done && !vec_wr_en && !hist_rd_en && !score_rd_en, "R1",
            "strobes in reset", {done, vec_wr_en, hist_rd_en, score_rd_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(thresh == 0 && thresh2 == 0, "R1", "thresholds after reset",
            thresh + thresh2, 0);
        chk(!done && !vec_wr_en && !hist_rd_en && !score_rd_en, "R1",
            "strobes after reset", {done, vec_wr_en, hist_rd_en, score_rd_en}, 0);

        foreach (VECS[c])
            run_case(int'(VECS[c].mode), VECS[c].a, VECS[c].b, 1'b0, 1'b0);

        // R8: start during the histogram walk must not restart it
        run_case(0, 7, 3, 1'b1, 1'b0);
        // R8: start in the done cycle must be ignored
        run_case(1, 20, 100, 1'b0, 1'b1);
        chk(rd_cnt == MAXB - 99, "R8", "no reads after start in done cycle",
            rd_cnt, MAXB - 99);
        chk(done_cnt == 1, "R8", "no second run after start in done cycle", done_cnt, 1);

        summary();
    end
endmodule